// File: doc/BRIEF.md
# Port Change Interrupt Detector

This block watches a small general-purpose port and pulls an interrupt line low whenever a pin that is set as an input moves away from the level last reported to the host. Each pin level passes through a two-flop synchronizer. The synchronized levels are then compared with a snapshot register. That register holds the value the host saw at its most recent read of the input register. The comparison is masked by the per-pin direction bits, so pins driven as outputs never take part.

The interrupt clears in two ways. One is that the input pins return to the snapshot levels. The other is a read of the input register by this device's bus interface. Such a read is recognised by four qualifiers that are all high at the same clock edge: a serial-clock rising edge, the acknowledge bit slot, the addressed register being the input register, and an address match for this device. On that edge the snapshot takes the current synchronized pin levels. Any change that arrives later raises the interrupt again. A change that reaches the synchronizer output at the clearing edge itself keeps the interrupt asserted.

The line is open-drain. It is modelled as a drive-low enable together with the level seen on the wire, which reads high when the line is released.

Top module: `pin_change_irq`

## Requirements
- R1: A rising or a falling level change on any pin whose direction bit is 1 (input) sets `irqDriveLow` to 1 at the second rising clock edge after the change on `pinAsync`.
- R2: When every input pin returns to its snapshot level, `irqDriveLow` goes back to 0 at the second clock edge after the return.
- R3: A clock edge at which `busSclRise`, `busAckSlot`, `busRegIsInput` and `busAddrHit` are all 1 loads the snapshot with the synchronized pin levels. If the pins are stable, `irqDriveLow` is 0 after that edge.
- R4: Pins whose direction bit is 0 (output) never set `irqDriveLow`, however their levels move.
- R5: After a clearing read, a new change on any input pin is detected again and sets `irqDriveLow` to 1.
- R6: If any of the four read qualifiers is 0 at an edge (for example `busAddrHit` = 0 for traffic to another device), that edge leaves the snapshot and `irqDriveLow` unchanged.
- R7: Changing a pin's direction bit from 0 to 1 while its synchronized level differs from the snapshot sets `irqDriveLow` to 1 one edge later.
- R8: If a new change reaches the synchronizer output at the same edge as a clearing read, `irqDriveLow` is 1 after that edge.
- R9: While `rstN` is 0, the snapshot follows the pin levels and `irqDriveLow` is 0. After release with stable pins, `irqDriveLow` stays 0 for any pin pattern.
- R10: `irqLevel` is 1 when the line is released (`irqDriveLow` = 0) and 0 when it is driven low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Synchronous active-low reset |
| pinAsync | input | PORT_W | Raw pin levels, asynchronous to clk |
| dirIsInput | input | PORT_W | Per-pin direction, 1 = input, 0 = output |
| busSclRise | input | 1 | Serial clock rising edge seen this cycle |
| busAckSlot | input | 1 | Bus is in the acknowledge / not-acknowledge bit |
| busRegIsInput | input | 1 | Current read targets the input register |
| busAddrHit | input | 1 | Current transfer is addressed to this device |
| irqDriveLow | output | 1 | 1 = pull the open-drain interrupt line low |
| irqLevel | output | 1 | Level seen on the line: 0 when driven, 1 when released |

## Verification
Single-pin rising and falling changes show that both edge directions are caught and that the output waits exactly two edges. Returning the pins to the snapshot separates a design that compares levels from one that latches an event. Changes on output-direction pins, followed by turning those pins into inputs, tell the mask apart from a missing mask and check the false-interrupt case on a direction switch. Read strobes with one qualifier missing, followed by a return to the old levels, show that the snapshot was not reloaded. A change timed to land on the clearing edge separates a snapshot taken from the synchronizer output from one taken a stage earlier.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic snapFromSynced;  // clearing read: snapshot <= current synced pins
    logic snapFromStage;   // reset: snapshot tracks the next synced value
    logic forceRelease;    // reset: hold the line released
  } pcirq_ctl_t;

endpackage

// File: rtl/pcirq_sync.sv
module pcirq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] din,
  output logic [W-1:0] preLast,
  output logic [W-1:0] synced
);

  localparam int LAST = STAGES - 1;

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= din;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) chain[s] <= chain[s-1];
  end

  assign preLast = chain[LAST-1];
  assign synced  = chain[LAST];

endmodule

// File: rtl/pcirq_ctrl.sv
module pcirq_ctrl
  import pcirq_pkg::*;
(
  input  logic       rstN,
  input  logic       busSclRise,
  input  logic       busAckSlot,
  input  logic       busRegIsInput,
  input  logic       busAddrHit,
  output pcirq_ctl_t ctl
);

  logic readAck;

  always_comb begin
    readAck = busSclRise & busAckSlot & busRegIsInput & busAddrHit;
    ctl.snapFromStage  = !rstN;
    ctl.forceRelease   = !rstN;
    ctl.snapFromSynced = rstN & readAck;
  end

endmodule

// File: rtl/pcirq_datapath.sv
module pcirq_datapath
  import pcirq_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  pcirq_ctl_t        ctl,
  input  logic [PORT_W-1:0] pinAsync,
  input  logic [PORT_W-1:0] dirIsInput,
  output logic [PORT_W-1:0] stagePins,
  output logic [PORT_W-1:0] syncedPins,
  output logic [PORT_W-1:0] snapshot,
  output logic              irqDriveLow
);

  logic [PORT_W-1:0] snapNext;
  logic [PORT_W-1:0] diffNext;

  pcirq_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .din     (pinAsync),
    .preLast (stagePins),
    .synced  (syncedPins)
  );

  always_comb begin
    if (ctl.snapFromStage)       snapNext = stagePins;
    else if (ctl.snapFromSynced) snapNext = syncedPins;
    else                         snapNext = snapshot;
    // stagePins is what syncedPins becomes at this edge
    diffNext = (stagePins ^ snapNext) & dirIsInput;
  end

  always_ff @(posedge clk) begin
    snapshot    <= snapNext;
    irqDriveLow <= ctl.forceRelease ? 1'b0 : (|diffNext);
  end

endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pcirq_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] pinAsync,
  input  logic [PORT_W-1:0] dirIsInput,
  input  logic              busSclRise,
  input  logic              busAckSlot,
  input  logic              busRegIsInput,
  input  logic              busAddrHit,
  output logic              irqDriveLow,
  output logic              irqLevel
);

  pcirq_ctl_t        ctl;
  logic [PORT_W-1:0] stagePins;
  logic [PORT_W-1:0] syncedPins;
  logic [PORT_W-1:0] snapshot;

  pcirq_ctrl uCtrl (
    .rstN          (rstN),
    .busSclRise    (busSclRise),
    .busAckSlot    (busAckSlot),
    .busRegIsInput (busRegIsInput),
    .busAddrHit    (busAddrHit),
    .ctl           (ctl)
  );

  pcirq_datapath #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk         (clk),
    .ctl         (ctl),
    .pinAsync    (pinAsync),
    .dirIsInput  (dirIsInput),
    .stagePins   (stagePins),
    .syncedPins  (syncedPins),
    .snapshot    (snapshot),
    .irqDriveLow (irqDriveLow)
  );

  // Open-drain: wire reads high unless driven
  assign irqLevel = ~irqDriveLow;

endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk #(
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [PORT_W-1:0] dirIsInput,
  input logic              busSclRise,
  input logic              busAckSlot,
  input logic              busRegIsInput,
  input logic              busAddrHit,
  input logic [PORT_W-1:0] stagePins,
  input logic [PORT_W-1:0] syncedPins,
  input logic [PORT_W-1:0] snapshot,
  input logic              irqDriveLow,
  input logic              irqLevel
);

  logic clr;
  assign clr = busSclRise & busAckSlot & busRegIsInput & busAddrHit;

  // R3: clearing read with stable pins releases the line
  assert_clear_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clr && stagePins == syncedPins) |=> !irqDriveLow);

  // R8: change landing on the clearing edge keeps the line driven
  assert_same_edge_keep_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clr && ((stagePins ^ syncedPins) & dirIsInput) != '0) |=> irqDriveLow);

  // R4: with every pin an output, the line is never driven
  assert_outputs_masked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dirIsInput == '0) |=> !irqDriveLow);

  // R6: a non-qualified edge keeps the snapshot
  assert_foreign_keep_R6: assert property (@(posedge clk) disable iff (!rstN)
    !clr |=> $stable(snapshot));

  // R2: inputs matching the snapshot release the line
  assert_match_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && ((stagePins ^ snapshot) & dirIsInput) == '0) |=> !irqDriveLow);

  // R1: input differing from snapshot drives the line
  assert_diff_drive_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && ((stagePins ^ snapshot) & dirIsInput) != '0) |=> irqDriveLow);

  // R9: line released on leaving reset
  assert_reset_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !irqDriveLow);

  // R10: wire level is the inverse of the drive enable
  assert_level_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqLevel == !irqDriveLow);

endmodule

bind pin_change_irq pin_change_irq_chk #(.PORT_W(PORT_W)) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .dirIsInput    (dirIsInput),
  .busSclRise    (busSclRise),
  .busAckSlot    (busAckSlot),
  .busRegIsInput (busRegIsInput),
  .busAddrHit    (busAddrHit),
  .stagePins     (stagePins),
  .syncedPins    (syncedPins),
  .snapshot      (snapshot),
  .irqDriveLow   (irqDriveLow),
  .irqLevel      (irqLevel)
);

// File: tb/sim_pin_change_irq.sv
module sim_pin_change_irq;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN;
  logic [W-1:0] pinAsync;
  logic [W-1:0] dirIsInput;
  logic         busSclRise, busAckSlot, busRegIsInput, busAddrHit;
  logic         irqDriveLow, irqLevel;

  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_change_irq #(.PORT_W(W), .SYNC_STAGES(2)) u0 (
    .clk           (clk),
    .rstN          (rstN),
    .pinAsync      (pinAsync),
    .dirIsInput    (dirIsInput),
    .busSclRise    (busSclRise),
    .busAckSlot    (busAckSlot),
    .busRegIsInput (busRegIsInput),
    .busAddrHit    (busAddrHit),
    .irqDriveLow   (irqDriveLow),
    .irqLevel      (irqLevel)
  );

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One edge with the chosen qualifiers, then all low
  task automatic busEdge(input logic scl, input logic ack, input logic reg_in, input logic hit);
    @(negedge clk);
    busSclRise = scl; busAckSlot = ack; busRegIsInput = reg_in; busAddrHit = hit;
    @(negedge clk);
    busSclRise = 0; busAckSlot = 0; busRegIsInput = 0; busAddrHit = 0;
  endtask

  task automatic tReset;
    rstN = 0; pinAsync = 8'hA5; dirIsInput = 8'hFF;
    busSclRise = 0; busAckSlot = 0; busRegIsInput = 0; busAddrHit = 0;
    waitEdges(5);
    check("R9 reset released", irqDriveLow, 1'b0);
    rstN = 1;
    waitEdges(3);
    check("R9 no irq after reset, pins 0xA5", irqDriveLow, 1'b0);
    check("R10 released level high", irqLevel, 1'b1);
  endtask

  task automatic tRiseReturn;
    pinAsync = 8'hA4;          // bit0 falls
    waitEdges(1);
    check("R1 not yet after one edge", irqDriveLow, 1'b0);
    waitEdges(1);
    check("R1 falling bit0 drives", irqDriveLow, 1'b1);
    check("R10 driven level low", irqLevel, 1'b0);
    pinAsync = 8'hA5;
    waitEdges(2);
    check("R2 return to snapshot releases", irqDriveLow, 1'b0);
    pinAsync = 8'hB5;          // bit4 rises
    waitEdges(2);
    check("R1 rising bit4 drives", irqDriveLow, 1'b1);
    pinAsync = 8'hA5;
    waitEdges(2);
  endtask

  task automatic tClearRedetect;
    pinAsync = 8'h25;          // bit7 falls
    waitEdges(2);
    check("R1 falling bit7 drives", irqDriveLow, 1'b1);
    busEdge(1, 1, 1, 1);
    check("R3 read-ack clears", irqDriveLow, 1'b0);
    waitEdges(2);
    check("R3 stays clear, snapshot 0x25", irqDriveLow, 1'b0);
    pinAsync = 8'hA5;
    waitEdges(2);
    check("R5 change after clear redetected", irqDriveLow, 1'b1);
    busEdge(1, 1, 1, 1);
    check("R3 second clear", irqDriveLow, 1'b0);
  endtask

  task automatic tMaskSwitch;
    dirIsInput = 8'h0F;
    waitEdges(1);
    pinAsync = 8'h55;          // upper nibble moves, all outputs
    waitEdges(3);
    check("R4 output pins ignored", irqDriveLow, 1'b0);
    dirIsInput = 8'hFF;        // upper pins become inputs, differ from 0xA5
    waitEdges(1);
    check("R7 direction switch raises", irqDriveLow, 1'b1);
    busEdge(1, 1, 1, 1);
    check("R3 clear after switch", irqDriveLow, 1'b0);
  endtask

  task automatic tForeign;
    pinAsync = 8'h57;          // bit1 rises vs snapshot 0x55
    waitEdges(2);
    check("R1 bit1 drives", irqDriveLow, 1'b1);
    busEdge(1, 1, 1, 0);
    check("R6 other device keeps irq", irqDriveLow, 1'b1);
    busEdge(1, 1, 0, 1);
    check("R6 other register keeps irq", irqDriveLow, 1'b1);
    busEdge(0, 1, 1, 1);
    check("R6 no scl edge keeps irq", irqDriveLow, 1'b1);
    busEdge(1, 0, 1, 1);
    check("R6 outside ack slot keeps irq", irqDriveLow, 1'b1);
    pinAsync = 8'h55;
    waitEdges(2);
    check("R6 snapshot not reloaded", irqDriveLow, 1'b0);
  endtask

  task automatic tSameEdge;
    @(negedge clk);
    pinAsync = 8'h54;          // first stage takes it at the next edge
    @(negedge clk);
    busSclRise = 1; busAckSlot = 1; busRegIsInput = 1; busAddrHit = 1;
    @(negedge clk);
    busSclRise = 0; busAckSlot = 0; busRegIsInput = 0; busAddrHit = 0;
    check("R8 change on clear edge kept", irqDriveLow, 1'b1);
    busEdge(1, 1, 1, 1);
    check("R3 clear with stable pins", irqDriveLow, 1'b0);
  endtask

  initial begin
    tReset();
    tRiseReturn();
    tClearRedetect();
    tMaskSwitch();
    tForeign();
    tSameEdge();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule